// File: doc/BRIEF.md
# Store Address and Byte-Lane Generator

This block sits in the store path of a 32-bit load/store unit. Each accepted request carries a base register value, a signed 16-bit displacement, the store data register and an access size. The block adds the sign-extended displacement to the base to form an unsigned 32-bit effective address. The addition wraps silently. It then clears the low address bits that the access size makes meaningless, so misaligned halfword and word stores never trap: they are aligned downward.

From the aligned address and the size it builds the byte-enable mask and the lane-placed write data for a 32-bit little-endian memory bus. Byte data is copied onto every lane, and halfword data onto both halves. The enable mask then picks the lanes the memory actually writes. All outputs come from one register stage. Bus handshaking and loads are handled elsewhere.

Top module: `stlane_gen`

## Requirements
- R1: The bus address of a byte store equals the base plus the sign-extended displacement, taken as an unsigned 32-bit value.
- R2: The displacement is sign-extended from bit 15. Base 0x00010000 with displacement 0x8000 gives address 0x00008000.
- R3: A byte store (size code 2'b00) sets exactly one enable, bit number address[1:0] (bit 0 is the lowest lane, data bits 7:0). The write data is the data register's bits 7:0 copied onto all four lanes.
- R4: A halfword store (size code 2'b01) forces address bit 0 to 0. It enables 4'b0011 when address bit 1 is 0 and 4'b1100 when it is 1. The write data is bits 15:0 of the data register copied onto both halves.
- R5: A word store (size code 2'b10) forces address bits 1:0 to 0, enables 4'b1111 and passes the whole data word unchanged.
- R6: The unused size code 2'b11 behaves exactly like a word store.
- R7: Results appear on the bus one rising clock edge after the request is sampled with req_valid high, and bus_valid is then 1.
- R8: While reset is held and after it is released, bus_valid, bus_addr, bus_be and bus_wdata are all zero until the first request is taken.
- R9: A cycle sampled with req_valid low gives bus_valid 0 and bus_be 4'b0000 on the next cycle.
- R10: Address arithmetic wraps modulo 2^32 with no overflow indication. Base 0xFFFFFFFF with displacement 0x0001 gives 0x00000000. Base 0 with displacement 0xFFFF gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Store request present this cycle |
| req_base | input | 32 | Base register value |
| req_disp | input | 16 | Signed displacement |
| req_data | input | 32 | Store data register |
| req_size | input | 2 | Access size: 00 byte, 01 halfword, 10 word, 11 word |
| bus_valid | output | 1 | Bus beat carries a store |
| bus_addr | output | 32 | Aligned effective address |
| bus_be | output | 4 | Byte enables, bit i for data bits 8i+7:8i |
| bus_wdata | output | 32 | Lane-placed write data |

## Verification
Every result, including the address, enables, write data and valid flag, is due on the first rising edge after the request is sampled. An idle cycle shows up one edge later as cleared enables. The bench drives each request on a falling edge and reads the bus on the next falling edge, half a period after that single register stage has updated. Expected values come from a small model of the requirements in the bench. Idle and reset checks are read at the same sampling point.

// File: rtl/stlane_pkg.sv
package stlane_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WIDE = 2'b11
    } st_size_e;

    // log2 of the access size in bytes
    function automatic logic [1:0] size_log2(st_size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_HALF: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // clip the access span to what the bus width can hold
    function automatic logic [1:0] clip_span(logic [1:0] span, int lane_bits);
        if (int'(span) > lane_bits) return 2'(lane_bits);
        return span;
    endfunction

endpackage

// File: rtl/st_ea_calc.sv
module st_ea_calc
    import stlane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [DISP_W-1:0] disp,
    input  logic [1:0]        span,
    output logic [ADDR_W-1:0] ea_aligned
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] ea_raw;
    logic [ADDR_W-1:0] low_mask;

    always_comb begin
        disp_ext   = {{EXT_W{disp[DISP_W-1]}}, disp};
        ea_raw     = base + disp_ext;          // wraps modulo 2^ADDR_W
        low_mask   = (ADDR_W'(1) << span) - ADDR_W'(1);
        ea_aligned = ea_raw & ~low_mask;
    end
endmodule

// File: rtl/st_lane_map.sv
module st_lane_map
    import stlane_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [$clog2(DATA_W/8)-1:0] lane_sel,
    input  logic [1:0]                  span,
    input  logic [DATA_W-1:0]           data,
    output logic [DATA_W/8-1:0]         be,
    output logic [DATA_W-1:0]           wdata
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] pick [LANE_BITS+1];
        // candidate source byte for each possible access span
        for (genvar k = 0; k <= LANE_BITS; k++) begin : g_span
            assign pick[k] = data[(i % (1 << k))*8 +: 8];
        end
        assign wdata[i*8 +: 8] = pick[span];
        // lane belongs to the size-aligned group the address points at
        assign be[i] = ((LANE_BITS'(i) >> span) == (lane_sel >> span));
    end
endmodule

// File: rtl/stlane_gen.sv
module stlane_gen
    import stlane_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_base,
    input  logic [DISP_W-1:0]    req_disp,
    input  logic [DATA_W-1:0]    req_data,
    input  logic [1:0]           req_size,
    output logic                 bus_valid,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W/8-1:0]  bus_be,
    output logic [DATA_W-1:0]    bus_wdata
);
    localparam int LANES     = DATA_W / 8;
    localparam int LANE_BITS = $clog2(LANES);

    typedef struct packed {
        logic              valid;
        st_size_e          size;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [DATA_W-1:0] wdata;
    } bus_beat_t;

    st_size_e          size_in;
    logic [1:0]        span;
    logic [ADDR_W-1:0] ea_aligned;
    logic [LANES-1:0]  be_d;
    logic [DATA_W-1:0] wdata_d;
    bus_beat_t         beat_d, beat_q;

    assign size_in = st_size_e'(req_size);
    assign span    = clip_span(size_log2(size_in), LANE_BITS);

    st_ea_calc #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) ea_i (
        .base       (req_base),
        .disp       (req_disp),
        .span       (span),
        .ea_aligned (ea_aligned)
    );

    st_lane_map #(.DATA_W(DATA_W)) lane_i (
        .lane_sel (ea_aligned[LANE_BITS-1:0]),
        .span     (span),
        .data     (req_data),
        .be       (be_d),
        .wdata    (wdata_d)
    );

    always_comb begin
        beat_d.valid = 1'b1;
        beat_d.size  = size_in;
        beat_d.addr  = ea_aligned;
        beat_d.be    = be_d;
        beat_d.wdata = wdata_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else if (req_valid) begin
            beat_q <= beat_d;
        end else begin
            beat_q.valid <= 1'b0;
            beat_q.be    <= '0;
        end
    end

    assign bus_valid = beat_q.valid;
    assign bus_addr  = beat_q.addr;
    assign bus_be    = beat_q.be;
    assign bus_wdata = beat_q.wdata;

    // ---------------- assertions ----------------
    logic [ADDR_W-1:0] chk_disp_ext;
    assign chk_disp_ext = ADDR_W'($signed(req_disp));

    assert_addr_sum_R1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'b00) |=>
            bus_addr == $past(req_base + chk_disp_ext));

    assert_byte_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && beat_q.size == SZ_BYTE) |->
            ($countones(bus_be) == 1 && bus_be[bus_addr[LANE_BITS-1:0]]));

    assert_half_align_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && beat_q.size == SZ_HALF) |->
            (bus_addr[0] == 1'b0 && $countones(bus_be) == 2));

    assert_word_align_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && (beat_q.size == SZ_WORD || beat_q.size == SZ_WIDE)) |->
            (bus_addr[LANE_BITS-1:0] == '0 && &bus_be));

    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> bus_valid);

    assert_idle_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!bus_valid && bus_be == '0));
endmodule

// File: tb/stlane_gen_tb_top.sv
module stlane_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_base;
    logic [15:0] req_disp;
    logic [31:0] req_data;
    logic [1:0]  req_size;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    stlane_gen dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
        .req_disp(req_disp), .req_data(req_data), .req_size(req_size),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_be(bus_be),
        .bus_wdata(bus_wdata)
    );

    // ---- reference model from the requirements ----
    function automatic logic [31:0] m_ea(logic [31:0] b, logic [15:0] d, logic [1:0] s);
        logic [31:0] ea;
        ea = b + {{16{d[15]}}, d};
        case (s)
            2'b00:   return ea;
            2'b01:   return ea & 32'hFFFF_FFFE;
            default: return ea & 32'hFFFF_FFFC;
        endcase
    endfunction

    function automatic logic [3:0] m_be(logic [31:0] ea, logic [1:0] s);
        case (s)
            2'b00:   return 4'b0001 << ea[1:0];
            2'b01:   return ea[1] ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] m_wd(logic [31:0] d, logic [1:0] s);
        case (s)
            2'b00:   return {4{d[7:0]}};
            2'b01:   return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive on a falling edge, read on the next falling edge
    task automatic store(string tag, logic [1:0] s, logic [31:0] b,
                         logic [15:0] d, logic [31:0] dat);
        logic [31:0] ea;
        req_valid = 1'b1; req_size = s; req_base = b; req_disp = d; req_data = dat;
        @(negedge clk);
        req_valid = 1'b0;
        ea = m_ea(b, d, s);
        check({tag, " valid"}, 32'(bus_valid), 32'd1);
        check({tag, " addr"},  bus_addr, ea);
        check({tag, " be"},    32'(bus_be), 32'(m_be(ea, s)));
        check({tag, " wdata"}, bus_wdata, m_wd(dat, s));
    endtask

    task automatic t_reset();
        rst = 1'b1; req_valid = 1'b1; req_size = 2'b10;
        req_base = 32'h1234_5678; req_disp = 16'h0; req_data = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        check("R8 reset valid", 32'(bus_valid), 32'd0);
        check("R8 reset addr",  bus_addr, 32'd0);
        check("R8 reset be",    32'(bus_be), 32'd0);
        check("R8 reset wdata", bus_wdata, 32'd0);
        req_valid = 1'b0; rst = 1'b0;
        @(negedge clk);
        check("R8 post-reset valid", 32'(bus_valid), 32'd0);
        check("R8 post-reset be",    32'(bus_be), 32'd0);
    endtask

    task automatic t_byte_lanes();
        for (int i = 0; i < 4; i++)
            store("R3 byte lane", 2'b00, 32'h0000_1000, 16'(i), 32'hA1B2_C3D4 + 32'(i));
        store("R1 byte sum", 2'b00, 32'h4000_0001, 16'h0102, 32'h0000_005A);
    endtask

    task automatic t_half();
        store("R4 half low",      2'b01, 32'h0000_2000, 16'h0000, 32'h1111_BEEF);
        store("R4 half high",     2'b01, 32'h0000_2000, 16'h0002, 32'h2222_CAFE);
        store("R4 half odd low",  2'b01, 32'h0000_2001, 16'h0000, 32'h3333_1234);
        store("R4 half odd high", 2'b01, 32'h0000_2000, 16'h0003, 32'h4444_5678);
    endtask

    task automatic t_word();
        store("R5 word aligned", 2'b10, 32'h0000_3000, 16'h0004, 32'hDEAD_BEEF);
        store("R5 word misal",   2'b10, 32'h0000_3003, 16'h0000, 32'h0BAD_F00D);
        store("R6 size 11",      2'b11, 32'h0000_3001, 16'h0002, 32'h1357_9BDF);
    endtask

    task automatic t_disp_wrap();
        store("R2 neg disp",   2'b00, 32'h0001_0000, 16'h8000, 32'h0000_0077);
        store("R2 neg half",   2'b01, 32'h0000_0100, 16'hFFFD, 32'h0000_ABCD);
        store("R10 wrap up",   2'b00, 32'hFFFF_FFFF, 16'h0001, 32'h0000_0011);
        store("R10 wrap down", 2'b00, 32'h0000_0000, 16'hFFFF, 32'h0000_0022);
        store("R10 wrap word", 2'b10, 32'hFFFF_FFFE, 16'h0004, 32'hCAFE_0000);
    endtask

    task automatic t_idle_timing();
        // back-to-back: each beat appears exactly one edge after its request
        req_valid = 1'b1; req_size = 2'b00; req_base = 32'h0000_0500;
        req_disp = 16'h0001; req_data = 32'h0000_00C1;
        @(negedge clk);
        req_size = 2'b10; req_disp = 16'h0008; req_data = 32'h5555_AAAA;
        check("R7 first beat be", 32'(bus_be), 32'h2);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 second beat addr", bus_addr, 32'h0000_0508);
        check("R7 second beat be",   32'(bus_be), 32'hF);
        @(negedge clk);
        check("R9 idle valid", 32'(bus_valid), 32'd0);
        check("R9 idle be",    32'(bus_be), 32'd0);
    endtask

    initial begin
        t_reset();
        t_byte_lanes();
        t_half();
        t_word();
        t_disp_wrap();
        t_idle_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule